// File: doc/BRIEF.md
# Corner-Turn Spectrum Buffer with Cross-Power Integrator

This block sits between the transform stage and the cross-multiplier of a frequency-domain correlator. Two antenna streams deliver complex spectra, one sample pair per accepted cycle. Each spectrum arrives with its channels in ascending order, and spectra follow each other back to back. The block collects M spectra, which together make one frame. It then reads the frame back transposed, so that the M samples of a given channel leave the memory on consecutive cycles.

Each pair read back is multiplied as X·conj(Y). Because the samples of one channel now arrive together, the products of a channel can be summed in a single running register instead of a per-channel accumulator memory. One complex sum per channel is emitted, with the channel index. The storage has two banks: one bank fills while the other drains. Both ends use a valid/ready handshake, and a stall on the output side eventually pushes back on the input.

Top module: `cturn_xint`

## Requirements
- R1: During and right after a synchronous active-high reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Each frame of M×N accepted input pairs yields exactly N results. `out_chan` runs 0, 1, …, N-1 within a frame, and frames come out in the order they were accepted.
- R3: `out_re` of channel c equals the sum over the M spectra of the frame of Xr·Yr + Xi·Yi for channel c. All arithmetic is exact two's complement.
- R4: `out_im` of channel c equals the sum over the M spectra of Xi·Yr − Xr·Yi for channel c.
- R5: Full-scale inputs, including the most negative code on every component, never overflow. The result width is 2·W+1+log2(M) bits.
- R6: An input pair is taken only in a cycle where `in_valid` and `in_ready` are both 1. Values presented while `in_valid` is 0 do not affect any result.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_chan`, `out_re` and `out_im` keep their values.
- R8: A bank is reused only after every one of its entries has been read. When both banks hold unread data, `in_ready` is 0, and input resumes once the older bank is drained.
- R9: With `out_ready` held at 1, frames can be streamed at one pair per cycle with no cycle of `in_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pair present |
| in_ready | output | 1 | Input pair can be taken |
| in_xr | input | W | Antenna X sample, real part (signed) |
| in_xi | input | W | Antenna X sample, imaginary part (signed) |
| in_yr | input | W | Antenna Y sample, real part (signed) |
| in_yi | input | W | Antenna Y sample, imaginary part (signed) |
| out_valid | output | 1 | Integrated result present |
| out_ready | input | 1 | Result taken by the consumer |
| out_chan | output | log2(N) | Channel index of the result |
| out_re | output | 2W+1+log2(M) | Real part of the integrated cross-power (signed) |
| out_im | output | 2W+1+log2(M) | Imaginary part of the integrated cross-power (signed) |

## Verification
The bench feeds frames of several kinds, and each kind tells apart a different kind of fault:
- A constant frame confirms basic summation.
- A frame whose values encode both segment and channel exposes any transposition or address-ordering error, since a swapped or mis-grouped read gives a different sum.
- Two full-scale frames, all most-negative and mixed extremes, reveal truncated or unsigned arithmetic.
- Pseudo-random frames with input gaps, carrying junk data in the idle cycles, check that only handshaked pairs count.

The output side is first held off so that both banks fill and input must stop. It is then released with a pseudo-random ready pattern, and finally held open while two frames are streamed without gaps to confirm that the input never stalls.

// File: rtl/cturn_pkg.sv
package cturn_pkg;

  // width of one complex cross-product component for W-bit samples
  function automatic int prod_width(input int w);
    return 2 * w + 1;
  endfunction

  // width of the integrator holding m such products without overflow
  function automatic int sum_width(input int w, input int m);
    return 2 * w + 1 + $clog2(m);
  endfunction

  // position of a read-back sample inside its channel group
  typedef struct packed {
    logic first;
    logic last;
  } grp_tag_t;

endpackage

// File: rtl/cturn_bank_ram.sv
module cturn_bank_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read with enable: maps onto a simple dual-port block RAM
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/cturn_rd_seq.sv
module cturn_rd_seq #(
  parameter int NCH  = 8,
  parameter int MSEG = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              advance,
  input  logic [1:0]                        bank_full,
  output logic                              rd_en,
  output logic [$clog2(NCH*MSEG):0]         rd_addr,
  output cturn_pkg::grp_tag_t               rd_tag,
  output logic [$clog2(NCH)-1:0]            rd_chan,
  output logic [1:0]                        release_bank
);

  localparam int CW = $clog2(NCH);
  localparam int SW = $clog2(MSEG);

  logic          bank;
  logic [CW-1:0] ch;
  logic [SW-1:0] sg;
  logic          seg_end;
  logic          ch_end;

  assign seg_end = (sg == SW'(MSEG - 1));
  assign ch_end  = (ch == CW'(NCH - 1));
  assign rd_en   = advance & bank_full[bank];

  // segment index is the fastest-moving field: channel-major readout
  assign rd_addr      = {bank, sg, ch};
  assign rd_chan      = ch;
  assign rd_tag.first = (sg == '0);
  assign rd_tag.last  = seg_end;

  always_comb begin
    release_bank = 2'b00;
    if (rd_en && seg_end && ch_end) release_bank[bank] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank <= 1'b0;
      ch   <= '0;
      sg   <= '0;
    end else if (rd_en) begin
      sg <= sg + 1'b1;
      if (seg_end) begin
        ch <= ch + 1'b1;
        if (ch_end) bank <= ~bank;
      end
    end
  end

endmodule

// File: rtl/cturn_cmac.sv
module cturn_cmac #(
  parameter int W    = 8,
  parameter int NCH  = 8,
  parameter int MSEG = 4
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         advance,
  input  logic                                         in_vld,
  input  cturn_pkg::grp_tag_t                          in_tag,
  input  logic [$clog2(NCH)-1:0]                       in_chan,
  input  logic signed [W-1:0]                          xr,
  input  logic signed [W-1:0]                          xi,
  input  logic signed [W-1:0]                          yr,
  input  logic signed [W-1:0]                          yi,
  output logic                                         out_valid,
  output logic [$clog2(NCH)-1:0]                       out_chan,
  output logic signed [cturn_pkg::sum_width(W,MSEG)-1:0] out_re,
  output logic signed [cturn_pkg::sum_width(W,MSEG)-1:0] out_im
);

  localparam int MW = 2 * W;
  localparam int PW = cturn_pkg::prod_width(W);
  localparam int OW = cturn_pkg::sum_width(W, MSEG);

  logic signed [MW-1:0] xr_e, xi_e, yr_e, yi_e;
  logic signed [MW-1:0] m_rr, m_ii, m_ir, m_ri;
  logic signed [PW-1:0] p_re, p_im;
  logic signed [OW-1:0] acc_re, acc_im;
  logic signed [OW-1:0] nxt_re, nxt_im;

  assign xr_e = MW'(xr);
  assign xi_e = MW'(xi);
  assign yr_e = MW'(yr);
  assign yi_e = MW'(yi);

  assign m_rr = xr_e * yr_e;
  assign m_ii = xi_e * yi_e;
  assign m_ir = xi_e * yr_e;
  assign m_ri = xr_e * yi_e;

  // X * conj(Y)
  assign p_re = PW'(m_rr) + PW'(m_ii);
  assign p_im = PW'(m_ir) - PW'(m_ri);

  // first product of a group restarts the running sum
  assign nxt_re = in_tag.first ? OW'(p_re) : acc_re + OW'(p_re);
  assign nxt_im = in_tag.first ? OW'(p_im) : acc_im + OW'(p_im);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_re    <= '0;
      acc_im    <= '0;
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_re    <= '0;
      out_im    <= '0;
    end else if (advance) begin
      out_valid <= 1'b0;
      if (in_vld) begin
        acc_re <= nxt_re;
        acc_im <= nxt_im;
        if (in_tag.last) begin
          out_valid <= 1'b1;
          out_chan  <= in_chan;
          out_re    <= nxt_re;
          out_im    <= nxt_im;
        end
      end
    end
  end

endmodule

// File: rtl/cturn_xint.sv
module cturn_xint #(
  parameter int W    = 8,
  parameter int NCH  = 8,
  parameter int MSEG = 4
) (
  input  logic                                           clk,
  input  logic                                           rst,
  input  logic                                           in_valid,
  output logic                                           in_ready,
  input  logic signed [W-1:0]                            in_xr,
  input  logic signed [W-1:0]                            in_xi,
  input  logic signed [W-1:0]                            in_yr,
  input  logic signed [W-1:0]                            in_yi,
  output logic                                           out_valid,
  input  logic                                           out_ready,
  output logic [$clog2(NCH)-1:0]                         out_chan,
  output logic signed [cturn_pkg::sum_width(W,MSEG)-1:0] out_re,
  output logic signed [cturn_pkg::sum_width(W,MSEG)-1:0] out_im
);

  localparam int CW    = $clog2(NCH);
  localparam int DEPTH = NCH * MSEG;
  localparam int AW    = $clog2(DEPTH);
  localparam int LW    = 2 * W;

  // ---------------- write side ----------------
  logic          wr_bank;
  logic [AW-1:0] wr_cnt;
  logic [1:0]    bank_full;
  logic [1:0]    release_bank;
  logic          accept;
  logic          fill_done;

  assign in_ready  = ~bank_full[wr_bank];
  assign accept    = in_valid & in_ready;
  assign fill_done = accept && (wr_cnt == AW'(DEPTH - 1));

  // linear count equals segment * NCH + channel
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_bank <= 1'b0;
      wr_cnt  <= '0;
    end else if (accept) begin
      wr_cnt <= wr_cnt + 1'b1;
      if (fill_done) wr_bank <= ~wr_bank;
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)                                 bank_full[b] <= 1'b0;
      else if (fill_done && wr_bank == 1'(b))  bank_full[b] <= 1'b1;
      else if (release_bank[b])                bank_full[b] <= 1'b0;
    end
  end

  // ---------------- read side ----------------
  logic                 advance;
  logic                 rd_en;
  logic [AW:0]          rd_addr;
  cturn_pkg::grp_tag_t  rd_tag;
  logic [CW-1:0]        rd_chan;

  assign advance = ~out_valid | out_ready;

  cturn_rd_seq #(.NCH(NCH), .MSEG(MSEG)) u_rd (
    .clk          (clk),
    .rst          (rst),
    .advance      (advance),
    .bank_full    (bank_full),
    .rd_en        (rd_en),
    .rd_addr      (rd_addr),
    .rd_tag       (rd_tag),
    .rd_chan      (rd_chan),
    .release_bank (release_bank)
  );

  // ---------------- storage: one RAM per antenna lane ----------------
  logic [LW-1:0] lane_wdata [2];
  logic [LW-1:0] lane_rdata [2];

  assign lane_wdata[0] = {in_xr, in_xi};
  assign lane_wdata[1] = {in_yr, in_yi};

  for (genvar l = 0; l < 2; l++) begin : g_lane
    cturn_bank_ram #(.DW(LW), .DEPTH(2 * DEPTH)) u_ram (
      .clk   (clk),
      .we    (accept),
      .waddr ({wr_bank, wr_cnt}),
      .wdata (lane_wdata[l]),
      .re    (rd_en),
      .raddr (rd_addr),
      .rdata (lane_rdata[l])
    );
  end

  // tags travel alongside the one-cycle RAM read
  logic                s1_vld;
  cturn_pkg::grp_tag_t s1_tag;
  logic [CW-1:0]       s1_chan;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_tag  <= '0;
      s1_chan <= '0;
    end else if (advance) begin
      s1_vld  <= rd_en;
      s1_tag  <= rd_tag;
      s1_chan <= rd_chan;
    end
  end

  cturn_cmac #(.W(W), .NCH(NCH), .MSEG(MSEG)) u_mac (
    .clk       (clk),
    .rst       (rst),
    .advance   (advance),
    .in_vld    (s1_vld),
    .in_tag    (s1_tag),
    .in_chan   (s1_chan),
    .xr        ($signed(lane_rdata[0][LW-1:W])),
    .xi        ($signed(lane_rdata[0][W-1:0])),
    .yr        ($signed(lane_rdata[1][LW-1:W])),
    .yi        ($signed(lane_rdata[1][W-1:0])),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .out_re    (out_re),
    .out_im    (out_im)
  );

endmodule

// File: rtl/cturn_xint_chk.sv
module cturn_xint_chk #(
  parameter int W    = 8,
  parameter int NCH  = 8,
  parameter int MSEG = 4
) (
  input logic                                           clk,
  input logic                                           rst,
  input logic                                           in_valid,
  input logic                                           in_ready,
  input logic                                           out_valid,
  input logic                                           out_ready,
  input logic [$clog2(NCH)-1:0]                         out_chan,
  input logic signed [cturn_pkg::sum_width(W,MSEG)-1:0] out_re,
  input logic signed [cturn_pkg::sum_width(W,MSEG)-1:0] out_im
);

  localparam int CW    = $clog2(NCH);
  localparam int LIMIT = 2 * NCH * MSEG + 2 * MSEG;

  logic [CW-1:0]      exp_chan;
  logic signed [31:0] occ;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_chan <= '0;
      occ      <= '0;
    end else begin
      if (out_valid && out_ready) exp_chan <= exp_chan + 1'b1;
      occ <= occ + ((in_valid && in_ready) ? 32'sd1 : 32'sd0)
                 - ((out_valid && out_ready) ? 32'(MSEG) : 32'sd0);
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!out_valid && in_ready));

  // R2
  chan_order_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_chan == exp_chan));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_chan) && $stable(out_re) && $stable(out_im)));

  // R8
  occupancy_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= 32'(LIMIT));

endmodule

bind cturn_xint cturn_xint_chk #(.W(W), .NCH(NCH), .MSEG(MSEG)) u_chk (.*);

// File: tb/sim_cturn_xint.sv
module sim_cturn_xint;

  localparam int W    = 8;
  localparam int NCH  = 8;
  localparam int MSEG = 4;
  localparam int NF   = 8;
  localparam int OW   = 2 * W + 1 + $clog2(MSEG);

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic signed [W-1:0]  in_xr = '0, in_xi = '0, in_yr = '0, in_yi = '0;
  logic                 out_valid;
  logic                 out_ready = 1'b0;
  logic [$clog2(NCH)-1:0] out_chan;
  logic signed [OW-1:0] out_re, out_im;

  always #10 clk = ~clk;

  cturn_xint #(.W(W), .NCH(NCH), .MSEG(MSEG)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_xr(in_xr), .in_xi(in_xi), .in_yr(in_yr), .in_yi(in_yi),
    .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan),
    .out_re(out_re), .out_im(out_im)
  );

  int xr_a [NF][MSEG][NCH];
  int xi_a [NF][MSEG][NCH];
  int yr_a [NF][MSEG][NCH];
  int yi_a [NF][MSEG][NCH];

  int nchk = 0;
  int nerr = 0;
  int ocount = 0;
  int ready_mode = 0;
  int stalls = 0;
  logic [15:0] dlfsr = 16'hACE1;
  logic [15:0] rlfsr = 16'h1D2B;

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lstep(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic rnd8(output int v);
    dlfsr = lstep(dlfsr);
    dlfsr = lstep(dlfsr);
    v = int'($signed(dlfsr[7:0]));
  endtask

  task automatic fill_frame(input int f);
    for (int s = 0; s < MSEG; s++) begin
      for (int c = 0; c < NCH; c++) begin
        case (f)
          0: begin xr_a[f][s][c] = 3; xi_a[f][s][c] = -2; yr_a[f][s][c] = 5; yi_a[f][s][c] = 7; end
          1: begin xr_a[f][s][c] = s * 16 + c; xi_a[f][s][c] = -c;
                   yr_a[f][s][c] = s + 1; yi_a[f][s][c] = c - s; end
          2: begin xr_a[f][s][c] = -128; xi_a[f][s][c] = -128; yr_a[f][s][c] = -128; yi_a[f][s][c] = -128; end
          3: begin xr_a[f][s][c] = 127; xi_a[f][s][c] = -128; yr_a[f][s][c] = -128; yi_a[f][s][c] = 127; end
          default: begin
            rnd8(xr_a[f][s][c]); rnd8(xi_a[f][s][c]);
            rnd8(yr_a[f][s][c]); rnd8(yi_a[f][s][c]);
          end
        endcase
      end
    end
  endtask

  // R6: gaps carry junk values with in_valid low
  task automatic send_frame(input int f, input bit gaps);
    bit taken;
    fill_frame(f);
    for (int s = 0; s < MSEG; s++) begin
      for (int c = 0; c < NCH; c++) begin
        if (gaps && ((s * NCH + c) % 3 == 1)) begin
          @(negedge clk);
          in_valid = 1'b0;
          in_xr = 8'sd99; in_xi = -8'sd77; in_yr = 8'sd55; in_yi = -8'sd33;
        end
        do begin
          @(negedge clk);
          in_valid = 1'b1;
          in_xr = W'(xr_a[f][s][c]); in_xi = W'(xi_a[f][s][c]);
          in_yr = W'(yr_a[f][s][c]); in_yi = W'(yi_a[f][s][c]);
          taken = in_ready;
          if (!taken) stalls++;
        end while (!taken);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // output monitor and ready driver
  always @(negedge clk) begin
    if (!rst) begin
      if (ready_mode == 0)      out_ready = 1'b0;
      else if (ready_mode == 1) out_ready = 1'b1;
      else begin
        rlfsr = lstep(rlfsr);
        out_ready = rlfsr[0] | rlfsr[3];
      end
      if (out_valid && out_ready) begin
        automatic int f = ocount / NCH;
        automatic int c = ocount % NCH;
        automatic longint ere = 0;
        automatic longint eim = 0;
        if (f < NF) begin
          for (int s = 0; s < MSEG; s++) begin
            ere += longint'(xr_a[f][s][c]) * yr_a[f][s][c] + longint'(xi_a[f][s][c]) * yi_a[f][s][c];
            eim += longint'(xi_a[f][s][c]) * yr_a[f][s][c] - longint'(xr_a[f][s][c]) * yi_a[f][s][c];
          end
        end
        chk("R2 channel order", longint'(out_chan), longint'(c));
        if (f == 2 || f == 3) begin
          chk("R5 full-scale real", longint'(out_re), ere);
          chk("R5 full-scale imag", longint'(out_im), eim);
        end else if (f == 4 || f == 5) begin
          chk("R6 gapped real", longint'(out_re), ere);
          chk("R6 gapped imag", longint'(out_im), eim);
        end else begin
          chk("R3 real sum", longint'(out_re), ere);
          chk("R4 imag sum", longint'(out_im), eim);
        end
        ocount++;
      end
    end
  end

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d outputs", ocount, NF * NCH);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 in_ready after reset", longint'(in_ready), 1);
    chk("R1 out_valid after reset", longint'(out_valid), 0);

    // output held off: both banks fill
    send_frame(0, 1'b0);
    send_frame(1, 1'b0);
    repeat (12) @(negedge clk);
    chk("R8 in_ready with both banks full", longint'(in_ready), 0);
    chk("R7 result held while stalled", longint'(out_valid), 1);
    chk("R7 held channel", longint'(out_chan), 0);
    chk("R7 no result consumed", longint'(ocount), 0);

    // irregular consumer, input resumes after drain
    ready_mode = 2;
    send_frame(2, 1'b0);
    send_frame(3, 1'b0);
    send_frame(4, 1'b1);
    send_frame(5, 1'b1);
    while (ocount < 6 * NCH) @(negedge clk);

    // R9: open consumer, continuous streaming
    ready_mode = 1;
    stalls = 0;
    send_frame(6, 1'b0);
    send_frame(7, 1'b0);
    chk("R9 input stall cycles while streaming", longint'(stalls), 0);
    while (ocount < NF * NCH) @(negedge clk);
    repeat (20) @(negedge clk);
    chk("R2 total result count", longint'(ocount), NF * NCH);
    chk("R2 no extra result pending", longint'(out_valid), 0);
    summary();
    $finish;
  end

endmodule